// File: doc/BRIEF.md
# Interleaved Two-Channel Converter Word Splitter

This block sits at the digital edge of a dual-channel analog-to-digital converter whose two channels share one 14-bit parallel output bus. The converter places channel A's word on the bus for the rising edge of its own output clock and channel B's word for the falling edge. The block runs entirely on that converter clock. It takes the two words of each clock period and presents them as one pair of sign-extended 16-bit samples. Each channel's sample has its own valid strobe, and the two strobes rise together.

After reset the block drives a synchronisation pulse to the converter so that the converter's internal clock divider starts in a known phase. It then waits a fixed settling interval before it reports alignment and starts emitting pairs. A test mode replaces the captured words with a generated ramp on channel A and its bitwise complement on channel B. This lets the downstream logic check the path without an analog input.

Top module: `adc_pair_demux`

## Requirements
- R1: While reset is low, `sync_out` is 1, `aligned` is 0, both valid strobes are 0 and both data outputs are 0.
- R2: After reset is released, `sync_out` stays 1 through the first 3 rising edges and is 0 from the 4th rising edge onwards (SYNC_CYCLES = 4), until the next reset.
- R3: `aligned` rises at the 12th rising edge after reset release (SYNC_CYCLES + SETTLE_CYCLES with SETTLE_CYCLES = 8) and stays 1 until the next reset.
- R4: Both valid strobes are 0 until one rising edge after `aligned` rises. From then on both are 1 in every cycle, always equal to each other, one strobe per sample pair.
- R5: In normal mode, the pair presented after rising edge k holds channel A = the bus value at rising edge k-1 and channel B = the bus value at the falling edge that follows edge k-1.
- R6: Each 14-bit word is treated as two's complement. Output bits 15 and 14 equal bit 13, and bits 13..0 carry the word.
- R7: With `test_en` high at a rising edge where a pair is emitted, channel A carries a 14-bit ramp that is 0 at the first such pair and increments by 1 (mod 2^14) per pair. Channel B carries the 14-bit bitwise complement of channel A, both sign-extended as in R6.
- R8: A rising edge with `test_en` low clears the ramp to 0 and, once aligned, returns both channels to captured bus data on that pair.
- R9: Asserting reset in the middle of operation drops `aligned` and both strobes at once, raises `sync_out`, and the full sync/settle sequence of R2 and R3 repeats after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Clock supplied by the converter; both edges capture bus words |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_bus | input | 14 | Shared data bus, channel A word for the rising edge, channel B for the falling edge |
| test_en | input | 1 | Selects the generated ramp pattern instead of bus data |
| sync_out | output | 1 | Divider synchronisation pulse to the converter |
| aligned | output | 1 | High once the sync and settle sequence has finished |
| ch_a_data | output | 16 | Sign-extended channel A sample |
| ch_a_vld | output | 1 | Channel A sample strobe |
| ch_b_data | output | 16 | Sign-extended channel B sample |
| ch_b_vld | output | 1 | Channel B sample strobe |

## Verification
The rising-edge word and the falling-edge word of one converter period must meet in the same output cycle. The two words come from different registers clocked on opposite edges. The bench drives a different, distinct value for every half period over the full 14-bit range, so any one-edge slip or channel swap pairs the wrong words. Each emitted pair is compared against the A word from the previous rising edge and the B word from the falling edge that follows it. The second collision is between a test-mode switch and the first valid pair. The bench toggles `test_en` right at the alignment boundary and across a reset, and judges the ramp start value and the return to bus data on the exact edge.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/adc_edge_capture.sv
// Captures the shared bus on both edges of the converter clock.
module adc_edge_capture #(
    parameter int SAMPLE_W = 14
) (
    input  logic                dclk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] bus_i,
    output logic [SAMPLE_W-1:0] rise_o,
    output logic [SAMPLE_W-1:0] fall_o
);

    logic [SAMPLE_W-1:0] rise_d, rise_q;
    logic [SAMPLE_W-1:0] fall_d, fall_q;

    always_comb begin
        rise_d = bus_i;
        fall_d = bus_i;
    end

    // channel A word is on the bus at the rising edge
    always_ff @(posedge dclk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    // channel B word is on the bus at the falling edge
    always_ff @(negedge dclk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign rise_o = rise_q;
    assign fall_o = fall_q;

endmodule

// File: rtl/adc_align_seq.sv
// Sync pulse then settle interval, then run.
module adc_align_seq
    import adc_demux_pkg::*;
#(
    parameter int SYNC_CYCLES   = 4,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic dclk,
    input  logic rst_n,
    output logic sync_o,
    output logic run_o
);

    localparam int MAX_LEN = (SYNC_CYCLES > SETTLE_CYCLES) ? SYNC_CYCLES : SETTLE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] SYNC_LAST   = CNT_W'(SYNC_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_SYNC: begin
                if (seq_q.cnt == SYNC_LAST) begin
                    seq_d.phase = PH_SETTLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_SETTLE: begin
                if (seq_q.cnt == SETTLE_LAST) begin
                    seq_d.phase = PH_RUN;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.phase = PH_RUN;
                seq_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge dclk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_SYNC, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign sync_o = (seq_q.phase == PH_SYNC);
    assign run_o  = (seq_q.phase == PH_RUN);

endmodule

// File: rtl/adc_pair_format.sv
// Re-times the word pair into the rising-edge domain, selects test ramp, sign-extends.
module adc_pair_format
    import adc_demux_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int OUT_W    = 16
) (
    input  logic                             dclk,
    input  logic                             rst_n,
    input  logic                             run_i,
    input  logic                             test_i,
    input  logic [SAMPLE_W-1:0]              rise_i,
    input  logic [SAMPLE_W-1:0]              fall_i,
    output logic [NUM_CH-1:0][OUT_W-1:0]     word_o,
    output logic [NUM_CH-1:0]                vld_o
);

    localparam int EXT_W = OUT_W - SAMPLE_W;

    typedef struct packed {
        logic [SAMPLE_W-1:0]              pat;
        logic [NUM_CH-1:0]                vld;
        logic [NUM_CH-1:0][SAMPLE_W-1:0]  word;
    } fmt_t;

    fmt_t fmt_d, fmt_q;

    logic [NUM_CH-1:0][SAMPLE_W-1:0] live;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] ramp;

    assign live[0] = rise_i;
    assign live[1] = fall_i;
    assign ramp[0] = fmt_q.pat;
    assign ramp[1] = ~fmt_q.pat;

    always_comb begin
        fmt_d     = fmt_q;
        fmt_d.vld = {NUM_CH{run_i}};
        if (!test_i) begin
            fmt_d.pat = '0;
        end else if (run_i) begin
            fmt_d.pat = fmt_q.pat + 1'b1;
        end
        if (run_i) begin
            fmt_d.word = test_i ? ramp : live;
        end
    end

    always_ff @(posedge dclk or negedge rst_n) begin
        if (!rst_n) fmt_q <= '0;
        else        fmt_q <= fmt_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (EXT_W > 0) begin : g_ext
            assign word_o[c] = {{EXT_W{fmt_q.word[c][SAMPLE_W-1]}}, fmt_q.word[c]};
        end else begin : g_flat
            assign word_o[c] = fmt_q.word[c][OUT_W-1:0];
        end
        assign vld_o[c] = fmt_q.vld[c];
    end

endmodule

// File: rtl/adc_pair_demux.sv
module adc_pair_demux
    import adc_demux_pkg::*;
#(
    parameter int SAMPLE_W      = 14,
    parameter int OUT_W         = 16,
    parameter int SYNC_CYCLES   = 4,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic                dclk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] adc_bus,
    input  logic                test_en,
    output logic                sync_out,
    output logic                aligned,
    output logic [OUT_W-1:0]    ch_a_data,
    output logic                ch_a_vld,
    output logic [OUT_W-1:0]    ch_b_data,
    output logic                ch_b_vld
);

    logic [SAMPLE_W-1:0]          rise_w, fall_w;
    logic                         run_w;
    logic [NUM_CH-1:0][OUT_W-1:0] word_w;
    logic [NUM_CH-1:0]            vld_w;

    adc_edge_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
        .dclk   (dclk),
        .rst_n  (rst_n),
        .bus_i  (adc_bus),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    adc_align_seq #(
        .SYNC_CYCLES   (SYNC_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_seq (
        .dclk   (dclk),
        .rst_n  (rst_n),
        .sync_o (sync_out),
        .run_o  (run_w)
    );

    adc_pair_format #(
        .SAMPLE_W (SAMPLE_W),
        .OUT_W    (OUT_W)
    ) u_fmt (
        .dclk   (dclk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .test_i (test_en),
        .rise_i (rise_w),
        .fall_i (fall_w),
        .word_o (word_w),
        .vld_o  (vld_w)
    );

    assign aligned   = run_w;
    assign ch_a_data = word_w[0];
    assign ch_b_data = word_w[1];
    assign ch_a_vld  = vld_w[0];
    assign ch_b_vld  = vld_w[1];

endmodule

// File: rtl/adc_pair_demux_chk.sv
module adc_pair_demux_chk #(
    parameter int SAMPLE_W    = 14,
    parameter int OUT_W       = 16,
    parameter int SYNC_CYCLES = 4
) (
    input logic             dclk,
    input logic             rst_n,
    input logic             test_en,
    input logic             sync_out,
    input logic             aligned,
    input logic [OUT_W-1:0] ch_a_data,
    input logic             ch_a_vld,
    input logic [OUT_W-1:0] ch_b_data,
    input logic             ch_b_vld
);

    int sync_seen;

    always_ff @(posedge dclk or negedge rst_n) begin
        if (!rst_n)        sync_seen <= 0;
        else if (sync_out) sync_seen <= sync_seen + 1;
    end

    AST_SYNC_LEN: assert property (@(posedge dclk) disable iff (!rst_n)
        sync_seen <= SYNC_CYCLES); // R2

    AST_SYNC_EXCLUSIVE: assert property (@(posedge dclk) disable iff (!rst_n)
        sync_out |-> !aligned); // R2

    AST_ALIGN_HOLDS: assert property (@(posedge dclk) disable iff (!rst_n)
        aligned |=> aligned); // R3

    AST_VALID_AFTER_ALIGN: assert property (@(posedge dclk) disable iff (!rst_n)
        ch_a_vld |-> aligned); // R4

    AST_STROBES_TOGETHER: assert property (@(posedge dclk) disable iff (!rst_n)
        ch_a_vld == ch_b_vld); // R4

    AST_SIGN_COPY: assert property (@(posedge dclk) disable iff (!rst_n)
        ch_a_vld |-> (ch_a_data[OUT_W-1:SAMPLE_W-1] == {(OUT_W-SAMPLE_W+1){ch_a_data[SAMPLE_W-1]}})); // R6

    AST_RAMP_COMPLEMENT: assert property (@(posedge dclk) disable iff (!rst_n)
        (ch_b_vld && $past(test_en)) |-> (ch_b_data[SAMPLE_W-1:0] == ~ch_a_data[SAMPLE_W-1:0])); // R7

    AST_RAMP_STEP: assert property (@(posedge dclk) disable iff (!rst_n)
        (ch_a_vld && $past(ch_a_vld) && $past(test_en) && $past(test_en, 2))
        |-> (ch_a_data[SAMPLE_W-1:0] == SAMPLE_W'($past(ch_a_data[SAMPLE_W-1:0]) + 1'b1))); // R7

endmodule

bind adc_pair_demux adc_pair_demux_chk #(
    .SAMPLE_W    (SAMPLE_W),
    .OUT_W       (OUT_W),
    .SYNC_CYCLES (SYNC_CYCLES)
) u_chk (.*);

// File: tb/adc_pair_demux_test.sv
`timescale 1ns/1ps
module adc_pair_demux_test;

    localparam int SW     = 14;
    localparam int OW     = 16;
    localparam int N_SYNC = 4;
    localparam int N_SET  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] bus;
    logic          test_en;
    logic          sync_out, aligned, ch_a_vld, ch_b_vld;
    logic [OW-1:0] ch_a_data, ch_b_data;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    logic [SW-1:0] pat = '0;
    logic [SW-1:0] pa  = '0;
    logic [SW-1:0] pb  = '0;

    always #5 clk = ~clk;

    adc_pair_demux uut (
        .dclk      (clk),
        .rst_n     (rst_n),
        .adc_bus   (bus),
        .test_en   (test_en),
        .sync_out  (sync_out),
        .aligned   (aligned),
        .ch_a_data (ch_a_data),
        .ch_a_vld  (ch_a_vld),
        .ch_b_data (ch_b_data),
        .ch_b_vld  (ch_b_vld)
    );

    function automatic logic [OW-1:0] sext(input logic [SW-1:0] x);
        return {{(OW-SW){x[SW-1]}}, x};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at edge %0d: actual %h expected %h", req, n, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One converter period: A word before the rising edge, B word before the falling edge.
    task automatic cyc(input logic [SW-1:0] a, input logic [SW-1:0] b, input logic t);
        logic [SW-1:0] ea, eb;
        @(negedge clk); #2;
        bus = a;
        test_en = t;
        @(posedge clk); #1;
        n++;
        chk(sync_out == (n < N_SYNC), "R2 sync", 32'(sync_out), 32'(n < N_SYNC));
        chk(aligned == (n >= N_SYNC + N_SET), "R3 aligned", 32'(aligned), 32'(n >= N_SYNC + N_SET));
        chk({ch_a_vld, ch_b_vld} == {2{n >= N_SYNC + N_SET + 1}}, "R4 strobes",
            32'({ch_a_vld, ch_b_vld}), 32'({2{n >= N_SYNC + N_SET + 1}}));
        if (n >= N_SYNC + N_SET + 1) begin
            if (t) begin
                ea = pat;
                eb = ~pat;
                pat = pat + 1'b1;
                chk({ch_a_data, ch_b_data} == {sext(ea), sext(eb)}, "R7 R8 ramp",
                    {ch_a_data, ch_b_data}, {sext(ea), sext(eb)});
            end else begin
                ea = pa;
                eb = pb;
                chk({ch_a_data, ch_b_data} == {sext(ea), sext(eb)}, "R5 R6 pair",
                    {ch_a_data, ch_b_data}, {sext(ea), sext(eb)});
            end
        end
        if (!t) pat = '0;
        pa = a;
        #1;
        bus = b;
        pb = b;
    endtask

    initial begin
        #5_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired at edge %0d: actual hung expected done", n);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus = '0;
        test_en = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        // R1 reset state
        chk(sync_out == 1'b1, "R1 sync", 32'(sync_out), 32'd1);
        chk(aligned == 1'b0, "R1 aligned", 32'(aligned), 32'd0);
        chk({ch_a_vld, ch_b_vld} == 2'b00, "R1 strobes", 32'({ch_a_vld, ch_b_vld}), 32'd0);
        chk({ch_a_data, ch_b_data} == '0, "R1 data", {ch_a_data, ch_b_data}, 32'd0);
        rst_n = 1'b1;
        n = 0;

        // R5 R6: full sweep of channel A values, distinct B values
        for (int i = 0; i < (1 << SW); i++) begin
            cyc(SW'(i), SW'(i * 7 + 3), 1'b0);
        end

        // R7: ramp across a full wrap
        for (int i = 0; i < (1 << SW) + 100; i++) begin
            cyc(SW'(i ^ 5), SW'(i), 1'b1);
        end

        // R8: back to bus data, then ramp restarts at zero
        for (int i = 0; i < 20; i++) begin
            cyc(SW'(i + 8100), SW'(16383 - i), 1'b0);
        end
        for (int i = 0; i < 6; i++) begin
            cyc(SW'(i), SW'(i + 1), 1'b1);
        end
        cyc(14'h2000, 14'h1FFF, 1'b0);
        cyc(14'h3FFF, 14'h0000, 1'b0);

        // R9: reset during operation
        @(posedge clk); #3;
        rst_n = 1'b0;
        #1;
        chk(sync_out == 1'b1, "R9 sync", 32'(sync_out), 32'd1);
        chk(aligned == 1'b0, "R9 aligned", 32'(aligned), 32'd0);
        chk({ch_a_vld, ch_b_vld} == 2'b00, "R9 strobes", 32'({ch_a_vld, ch_b_vld}), 32'd0);
        @(posedge clk); #3;
        rst_n = 1'b1;
        n = 0;
        pat = '0;
        for (int i = 0; i < 30; i++) begin
            cyc(SW'(i * 3), SW'(i * 5), 1'b1);
        end
        for (int i = 0; i < 10; i++) begin
            cyc(SW'(i + 9000), SW'(i + 77), 1'b0);
        end

        summary();
        $finish;
    end

endmodule